// File: doc/BRIEF.md
# I2C-over-AUX Message Segmenter

This block takes a short list of I2C messages and turns it into a series of AUX-channel I2C transactions. Each message has a 7-bit target address, a direction flag and a length of 0 to 255 bytes. The block breaks every message into chunks of at most 16 bytes. It issues the chunks one at a time on a request/done transaction port and moves the payload between a flat byte buffer and that port. The middle-of-transaction flag stays set across chunk and message boundaries, so the far end holds the I2C bus until the final byte of the final message.

A host first presents the message table through a combinational lookup (`msg_idx` out; address, direction and length back). It then pulses `start`. The block walks the table and packs the messages back to back in the buffer, starting at offset 0. It ends with a single `done` pulse. That pulse carries either success and the number of messages completed, or the error code of the first failing chunk. The transaction engine that drives the wire is outside this block.

Top module: `i2c_aux_segmenter`

## Requirements
- R1: While `rst_n` is low, and after it rises until `start`, `busy`, `aux_req` and `done` are 0. Asserting `rst_n` low in the middle of a sequence drops `busy` and `aux_req` by the next clock edge.
- R2: A message of length L is sent as chunks of min(16, bytes left), in order. `aux_size` is the chunk size. `buf_ptr` starts at 0 for the first chunk of a sequence and advances by each chunk's size, continuing across messages.
- R3: `aux_cmd` bit 0 is 1 (I2C read) when the message's `msg_rd` is set and 0 (I2C write) otherwise. Bits 1 and 3 are always 0.
- R4: `aux_cmd` bit 2 (middle-of-transaction, value 0x4) is set when more than 16 bytes of the current message remain, or when any later message in the table exists, including a zero-length one.
- R5: The final chunk of the final message has `aux_cmd` bit 2 cleared.
- R6: When a read chunk completes without error, its `aux_size` received bytes are written to the buffer at `buf_ptr` (byte j of `aux_rdata` to `buf_ptr+j`) in the `aux_done` cycle. A failing chunk writes nothing.
- R7: During a write chunk, `aux_wdata` carries the buffer bytes at `buf_ptr` (byte j from `buf_ptr+j`).
- R8: A chunk answered with `aux_err` ends the sequence. One clock after that `aux_done`, `done` pulses with `done_err`=1 and `done_code` equal to `aux_code`. `done_count` is the number of messages fully completed before the failing one. No further chunk is requested.
- R9: When all chunks succeed, `done` pulses with `done_err`=0 and `done_count` = `msg_count`.
- R10: A zero-length message issues no chunk and is counted as completed.
- R11: With `msg_count` = 0, `done` pulses with `done_count` = 0 and no chunk is issued.
- R12: Once raised, `aux_req` and all chunk fields (`aux_cmd`, `aux_addr`, `aux_size`, `buf_ptr`) hold steady until the cycle in which `aux_done` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin processing the message table (taken when idle) |
| msg_count | input | 4 | Number of messages in the table (0..MAX_MSGS) |
| msg_idx | output | 4 | Index of the message being looked up |
| msg_addr | input | 7 | I2C address of message `msg_idx` |
| msg_rd | input | 1 | 1 = read message, 0 = write message |
| msg_len | input | 8 | Byte length of message `msg_idx` |
| buf_ptr | output | 12 | Buffer offset of the current chunk |
| buf_rdata | input | 128 | Buffer bytes at `buf_ptr` .. `buf_ptr+15` |
| buf_we | output | 1 | Write received bytes into the buffer |
| buf_wmask | output | 16 | Per-byte write enable (low `aux_size` bits set) |
| buf_wdata | output | 128 | Bytes to write at `buf_ptr` |
| aux_req | output | 1 | Chunk request, held until `aux_done` |
| aux_cmd | output | 4 | Chunk command: bit 0 read, bit 2 middle-of-transaction |
| aux_addr | output | 7 | I2C address for the chunk |
| aux_size | output | 5 | Chunk length in bytes (1..16) |
| aux_wdata | output | 128 | Payload for write chunks |
| aux_done | input | 1 | Chunk finished (one cycle) |
| aux_err | input | 1 | Chunk failed (valid with `aux_done`) |
| aux_code | input | 4 | Error code (valid with `aux_err`) |
| aux_rdata | input | 128 | Received bytes for read chunks (valid with `aux_done`) |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| done_err | output | 1 | Sequence ended on a failing chunk |
| done_code | output | 4 | Error code of the failing chunk |
| done_count | output | 4 | Messages completed |

## Verification
Two events can land on the same clock edge. The completion of a message's last chunk triggers both the buffer write of its received bytes and the step to the next message. A failing response on the final chunk of the final message competes with the successful end of the sequence. The stimulus table provokes the first case with read messages whose length is an exact multiple of 16 or whose last chunk is short, followed by more messages. The buffer contents and the pointer of the following chunk are then judged against offsets computed independently. The second case is provoked by erroring the only chunk of a one-message table. The outcome must be an error with a count of zero and an untouched buffer, never a success report.

// File: rtl/aux_seg_pkg.sv
package aux_seg_pkg;
  localparam int CMD_W = 4;
  localparam int CMD_RD_BIT  = 0;
  localparam int CMD_MOT_BIT = 2;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_FETCH = 2'd1,
    S_XFER  = 2'd2
  } seg_state_e;
endpackage

// File: rtl/aux_chunk_calc.sv
module aux_chunk_calc
  import aux_seg_pkg::*;
#(
  parameter int LEN_W = 8,
  parameter int CHUNK = 16,
  localparam int SZ_W = $clog2(CHUNK + 1)
) (
  input  logic [LEN_W-1:0] rem,
  input  logic             rd,
  input  logic             more_msgs,
  output logic [SZ_W-1:0]  size,
  output logic [CMD_W-1:0] cmd,
  output logic             last_chunk,
  output logic [CHUNK-1:0] byte_mask
);
  // size of the next chunk given the bytes still owed by the message
  function automatic logic [LEN_W-1:0] take_len(input logic [LEN_W-1:0] left);
    return (left > LEN_W'(CHUNK)) ? LEN_W'(CHUNK) : left;
  endfunction

  // bus stays held while this message continues or another one follows
  function automatic logic hold_bus(input logic [LEN_W-1:0] left, input logic later);
    return (left > LEN_W'(CHUNK)) || later;
  endfunction

  logic [LEN_W-1:0] take;
  assign take       = take_len(rem);
  assign size       = take[SZ_W-1:0];
  assign last_chunk = (rem <= LEN_W'(CHUNK));

  always_comb begin
    cmd = '0;
    cmd[CMD_RD_BIT]  = rd;
    cmd[CMD_MOT_BIT] = hold_bus(rem, more_msgs);
  end

  for (genvar i = 0; i < CHUNK; i++) begin : g_mask
    assign byte_mask[i] = (size > SZ_W'(i));
  end
endmodule

// File: rtl/aux_seg_fsm.sv
module aux_seg_fsm
  import aux_seg_pkg::*;
#(
  parameter int MAX_MSGS = 8,
  parameter int LEN_W    = 8,
  parameter int BUF_AW   = 12,
  parameter int CHUNK    = 16,
  parameter int ERR_W    = 4,
  localparam int SZ_W    = $clog2(CHUNK + 1),
  localparam int IDXW    = $clog2(MAX_MSGS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [IDXW-1:0]   msg_count,
  input  logic [LEN_W-1:0]  msg_len,
  input  logic [SZ_W-1:0]   chunk_size,
  input  logic              last_chunk,
  input  logic              aux_done,
  input  logic              aux_err,
  input  logic [ERR_W-1:0]  aux_code,
  output logic              in_xfer,
  output logic [IDXW-1:0]   msg_idx,
  output logic [BUF_AW-1:0] buf_ptr,
  output logic [LEN_W-1:0]  rem,
  output logic              more_msgs,
  output logic              chunk_ok,
  output logic              busy,
  output logic              done,
  output logic              done_err,
  output logic [ERR_W-1:0]  done_code,
  output logic [IDXW-1:0]   done_count
);
  seg_state_e        state;
  logic [IDXW-1:0]   idx_q, n_msgs_q;
  logic [BUF_AW-1:0] ptr_q;
  logic [LEN_W-1:0]  rem_q;

  // named internal events
  logic table_end, chunk_fail, skip_empty;
  assign table_end  = (idx_q >= n_msgs_q);
  assign in_xfer    = (state == S_XFER);
  assign chunk_ok   = in_xfer && aux_done && !aux_err;
  assign chunk_fail = in_xfer && aux_done && aux_err;
  assign skip_empty = (state == S_FETCH) && !table_end && (msg_len == '0);
  assign more_msgs  = ({1'b0, idx_q} + (IDXW+1)'(1)) < {1'b0, n_msgs_q};

  assign msg_idx = idx_q;
  assign buf_ptr = ptr_q;
  assign rem     = rem_q;
  assign busy    = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      idx_q      <= '0;
      n_msgs_q   <= '0;
      ptr_q      <= '0;
      rem_q      <= '0;
      done       <= 1'b0;
      done_err   <= 1'b0;
      done_code  <= '0;
      done_count <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        S_IDLE: if (start) begin
          idx_q    <= '0;
          ptr_q    <= '0;
          n_msgs_q <= msg_count;
          state    <= S_FETCH;
        end
        S_FETCH: begin
          if (table_end) begin
            done       <= 1'b1;
            done_err   <= 1'b0;
            done_count <= idx_q;
            state      <= S_IDLE;
          end else if (skip_empty) begin
            idx_q <= idx_q + IDXW'(1);
          end else begin
            rem_q <= msg_len;
            state <= S_XFER;
          end
        end
        S_XFER: begin
          if (chunk_fail) begin
            done       <= 1'b1;
            done_err   <= 1'b1;
            done_code  <= aux_code;
            done_count <= idx_q;
            state      <= S_IDLE;
          end else if (chunk_ok) begin
            ptr_q <= ptr_q + BUF_AW'(chunk_size);
            rem_q <= rem_q - LEN_W'(chunk_size);
            if (last_chunk) begin
              idx_q <= idx_q + IDXW'(1);
              state <= S_FETCH;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R12: a pending request keeps its chunk context
  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (in_xfer && !aux_done) |=> (in_xfer && $stable(ptr_q) && $stable(rem_q) && $stable(idx_q)));

  // R8: failure ends the run with an error report and no further request
  p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    chunk_fail |=> (!in_xfer && done && done_err));

  // R9: a clean finish reports every message of the table
  p_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !done_err) |-> (done_count == n_msgs_q));

  // R10: an empty message never opens a transfer
  p_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    skip_empty |=> !in_xfer);
endmodule

// File: rtl/i2c_aux_segmenter.sv
module i2c_aux_segmenter
  import aux_seg_pkg::*;
#(
  parameter int MAX_MSGS = 8,
  parameter int LEN_W    = 8,
  parameter int ADDR_W   = 7,
  parameter int BUF_AW   = 12,
  parameter int CHUNK    = 16,
  parameter int ERR_W    = 4,
  localparam int SZ_W    = $clog2(CHUNK + 1),
  localparam int IDXW    = $clog2(MAX_MSGS + 1),
  localparam int DATA_W  = CHUNK * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [IDXW-1:0]   msg_count,
  output logic [IDXW-1:0]   msg_idx,
  input  logic [ADDR_W-1:0] msg_addr,
  input  logic              msg_rd,
  input  logic [LEN_W-1:0]  msg_len,
  output logic [BUF_AW-1:0] buf_ptr,
  input  logic [DATA_W-1:0] buf_rdata,
  output logic              buf_we,
  output logic [CHUNK-1:0]  buf_wmask,
  output logic [DATA_W-1:0] buf_wdata,
  output logic              aux_req,
  output logic [CMD_W-1:0]  aux_cmd,
  output logic [ADDR_W-1:0] aux_addr,
  output logic [SZ_W-1:0]   aux_size,
  output logic [DATA_W-1:0] aux_wdata,
  input  logic              aux_done,
  input  logic              aux_err,
  input  logic [ERR_W-1:0]  aux_code,
  input  logic [DATA_W-1:0] aux_rdata,
  output logic              busy,
  output logic              done,
  output logic              done_err,
  output logic [ERR_W-1:0]  done_code,
  output logic [IDXW-1:0]   done_count
);
  logic [LEN_W-1:0] rem;
  logic             more_msgs, last_chunk, chunk_ok, in_xfer;
  logic [SZ_W-1:0]  chunk_size;
  logic [CHUNK-1:0] byte_mask;

  aux_chunk_calc #(.LEN_W(LEN_W), .CHUNK(CHUNK)) u_calc (
    .rem        (rem),
    .rd         (msg_rd),
    .more_msgs  (more_msgs),
    .size       (chunk_size),
    .cmd        (aux_cmd),
    .last_chunk (last_chunk),
    .byte_mask  (byte_mask)
  );

  aux_seg_fsm #(
    .MAX_MSGS(MAX_MSGS), .LEN_W(LEN_W), .BUF_AW(BUF_AW),
    .CHUNK(CHUNK), .ERR_W(ERR_W)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .msg_count  (msg_count),
    .msg_len    (msg_len),
    .chunk_size (chunk_size),
    .last_chunk (last_chunk),
    .aux_done   (aux_done),
    .aux_err    (aux_err),
    .aux_code   (aux_code),
    .in_xfer    (in_xfer),
    .msg_idx    (msg_idx),
    .buf_ptr    (buf_ptr),
    .rem        (rem),
    .more_msgs  (more_msgs),
    .chunk_ok   (chunk_ok),
    .busy       (busy),
    .done       (done),
    .done_err   (done_err),
    .done_code  (done_code),
    .done_count (done_count)
  );

  assign aux_req   = in_xfer;
  assign aux_addr  = msg_addr;
  assign aux_size  = chunk_size;
  assign aux_wdata = buf_rdata;
  assign buf_we    = chunk_ok && msg_rd;
  assign buf_wmask = byte_mask;
  assign buf_wdata = aux_rdata;

  // R2: every issued chunk carries 1..CHUNK bytes
  p_size_r2: assert property (@(posedge clk) disable iff (!rst_n)
    aux_req |-> (aux_size != '0 && aux_size <= SZ_W'(CHUNK)));

  // R3: direction bit follows the message flag, spare bits stay low
  p_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    aux_req |-> (aux_cmd[CMD_RD_BIT] == msg_rd && !aux_cmd[1] && !aux_cmd[3]));

  // R4: a long remainder keeps the bus held
  p_mot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (aux_req && rem > LEN_W'(CHUNK)) |-> aux_cmd[CMD_MOT_BIT]);

  // R5: final chunk of the final message releases the bus
  p_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (aux_req && last_chunk && !more_msgs) |-> !aux_cmd[CMD_MOT_BIT]);

  // R1: nothing is requested or reported while idle
  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!aux_req && !buf_we));
endmodule

// File: tb/i2c_aux_segmenter_bench.sv
`timescale 1ns/1ps
module i2c_aux_segmenter_bench;
  localparam int NV = 10;
  localparam int MAXC = 160;
  localparam int NONE = 255;

  // stimulus table: message count, lengths (byte m = message m), read flags,
  // failing chunk (255 = none), response latency in cycles
  localparam logic [3:0]  VN  [NV] = '{4'd1, 4'd1, 4'd1, 4'd3, 4'd2, 4'd2, 4'd0, 4'd2, 4'd8, 4'd1};
  localparam logic [63:0] VLEN[NV] = '{64'h05, 64'h10, 64'h11, 64'h0003_0014, 64'h01FF,
                                       64'h0A28, 64'h0, 64'h0003, 64'h0021_2011_100F_0201, 64'h10};
  localparam logic [7:0]  VRD [NV] = '{8'h00, 8'h01, 8'h00, 8'h01, 8'h01, 8'h02, 8'h00, 8'h00, 8'hAA, 8'h01};
  localparam int          VERR[NV] = '{NONE, NONE, NONE, NONE, NONE, 1, NONE, NONE, NONE, 0};
  localparam int          VLAT[NV] = '{1, 2, 1, 1, 3, 1, 1, 2, 1, 1};

  logic clk = 0, rst_n = 0, start = 0;
  logic [3:0] msg_count = 0, msg_idx;
  logic [6:0] msg_addr;
  logic msg_rd;
  logic [7:0] msg_len;
  logic [11:0] buf_ptr;
  logic [127:0] buf_rdata, buf_wdata, aux_wdata, aux_rdata;
  logic buf_we, aux_req, aux_done, aux_err, busy, done, done_err;
  logic [15:0] buf_wmask;
  logic [3:0] aux_cmd, aux_code, done_code, done_count;
  logic [6:0] aux_addr;
  logic [4:0] aux_size;

  always #4 clk = ~clk;

  i2c_aux_segmenter u_i2c_aux_segmenter (.*);

  int checks = 0, fails = 0;
  bit finished = 0;

  // message table seen by the block
  logic [7:0] t_len [8];
  logic       t_rd  [8];
  assign msg_len  = (msg_idx < 8) ? t_len[msg_idx[2:0]] : 8'd0;
  assign msg_rd   = (msg_idx < 8) ? t_rd[msg_idx[2:0]]  : 1'b0;
  assign msg_addr = 7'h50 + 7'(msg_idx);

  // byte buffer
  logic [7:0] mem [4096];
  logic preload = 0;
  always_comb
    for (int j = 0; j < 16; j++) buf_rdata[8*j +: 8] = mem[buf_ptr + 12'(j)];
  always @(posedge clk) begin
    if (preload) begin
      for (int a = 0; a < 4096; a++) mem[a] <= 8'(a) ^ 8'hC3;
    end else if (buf_we) begin
      for (int j = 0; j < 16; j++)
        if (buf_wmask[j]) mem[buf_ptr + 12'(j)] <= buf_wdata[8*j +: 8];
    end
  end

  // expected chunk list, computed from the requirements
  int exp_size[MAXC], exp_cmd[MAXC], exp_ptr[MAXC], exp_addr[MAXC], exp_msg[MAXC], exp_rd[MAXC];
  int exp_n, err_at, cur_lat, k;

  task automatic build_expect(input int n);
    int off = 0;
    exp_n = 0;
    for (int m = 0; m < n; m++) begin
      int left = int'(t_len[m]);
      while (left > 0) begin
        int c = (left > 16) ? 16 : left;
        exp_size[exp_n] = c;
        exp_ptr[exp_n]  = off;
        exp_addr[exp_n] = 'h50 + m;
        exp_rd[exp_n]   = int'(t_rd[m]);
        exp_msg[exp_n]  = m;
        exp_cmd[exp_n]  = (t_rd[m] ? 1 : 0) + ((left > 16 || m < n - 1) ? 4 : 0);
        off += c; left -= c; exp_n++;
      end
    end
  endtask

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // transaction engine model
  initial begin
    aux_done = 0; aux_err = 0; aux_code = 4'hB; aux_rdata = '0;
    forever begin
      @(negedge clk);
      aux_done = 0; aux_err = 0;
      if (aux_req && rst_n) begin
        if (k >= exp_n || (err_at != NONE && k > err_at)) begin
          check(0, "R8", "unexpected chunk", k, exp_n);
        end else begin
          check(int'(aux_size) == exp_size[k], "R2", "chunk size", int'(aux_size), exp_size[k]);
          check(int'(buf_ptr) == exp_ptr[k], "R2", "chunk pointer", int'(buf_ptr), exp_ptr[k]);
          check(int'(aux_addr) == exp_addr[k], "R2", "chunk address", int'(aux_addr), exp_addr[k]);
          check(int'(aux_cmd[0]) + 2*int'(aux_cmd[1]) + 8*int'(aux_cmd[3]) == (exp_cmd[k] & 1),
                "R3", "direction bits", int'(aux_cmd), exp_cmd[k]);
          if (k == exp_n - 1)
            check(int'(aux_cmd) == exp_cmd[k], "R5", "final command", int'(aux_cmd), exp_cmd[k]);
          else
            check(int'(aux_cmd) == exp_cmd[k], "R4", "held command", int'(aux_cmd), exp_cmd[k]);
          if (exp_rd[k] == 0)
            for (int j = 0; j < exp_size[k]; j++)
              check(aux_wdata[8*j +: 8] == (8'(exp_ptr[k] + j) ^ 8'hC3), "R7", "write byte",
                    int'(aux_wdata[8*j +: 8]), int'(8'(exp_ptr[k] + j) ^ 8'hC3));
        end
        repeat (cur_lat - 1) @(negedge clk);
        for (int j = 0; j < 16; j++) aux_rdata[8*j +: 8] = 8'(k * 16 + j + 1);
        aux_done = 1;
        aux_err  = (k == err_at);
        k++;
      end
    end
  end

  task automatic run_vector(input int v);
    int n = int'(VN[v]);
    int exp_cnt, issued, bad;
    for (int m = 0; m < 8; m++) begin
      t_len[m] = VLEN[v][8*m +: 8];
      t_rd[m]  = VRD[v][m];
    end
    build_expect(n);
    err_at = VERR[v]; cur_lat = VLAT[v]; k = 0;
    msg_count = 4'(n);
    @(negedge clk) preload = 1;
    @(negedge clk) preload = 0; start = 1;
    @(negedge clk) start = 0;
    while (!done) @(negedge clk);
    if (err_at == NONE) begin
      check(!done_err, "R9", "error flag", int'(done_err), 0);
      check(int'(done_count) == n, n == 0 ? "R11" : "R9", "message count", int'(done_count), n);
      exp_cnt = exp_n;
    end else begin
      check(done_err && done_code == 4'hB, "R8", "error report", int'(done_code), 11);
      check(int'(done_count) == exp_msg[err_at], "R8", "count at error", int'(done_count), exp_msg[err_at]);
      exp_cnt = err_at + 1;
    end
    repeat (3) @(negedge clk);
    issued = k;
    check(issued == exp_cnt, VN[v] == 0 ? "R11" : "R10", "chunks issued", issued, exp_cnt);
    check(!busy && !aux_req, "R8", "idle after end", int'(busy), 0);
    bad = 0;
    for (int c = 0; c < exp_n; c++)
      for (int j = 0; j < exp_size[c]; j++) begin
        int a = exp_ptr[c] + j;
        logic [7:0] e = (exp_rd[c] != 0 && (err_at == NONE || c < err_at)) ? 8'(c * 16 + j + 1)
                                                                          : (8'(a) ^ 8'hC3);
        if (mem[a] != e) bad++;
      end
    check(bad == 0, "R6", "buffer bytes wrong", bad, 0);
  endtask

  initial begin
    k = 0; exp_n = 0; err_at = NONE; cur_lat = 1;
    for (int m = 0; m < 8; m++) begin t_len[m] = 0; t_rd[m] = 0; end
    repeat (3) @(negedge clk);
    check(!busy && !aux_req && !done, "R1", "state in reset", int'(busy), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check(!busy && !aux_req && !done, "R1", "state after reset", int'(busy), 0);
    for (int v = 0; v < NV; v++) run_vector(v);
    // directed: reset in the middle of a long read
    for (int m = 0; m < 8; m++) begin t_len[m] = VLEN[4][8*m +: 8]; t_rd[m] = VRD[4][m]; end
    build_expect(2); err_at = NONE; cur_lat = 1; k = 0; msg_count = 4'd2;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    repeat (10) @(negedge clk);
    check(busy && aux_req, "R1", "running before reset", int'(busy), 1);
    rst_n = 0;
    @(negedge clk);
    check(!busy && !aux_req, "R1", "reset mid-sequence", int'(aux_req), 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check(!busy && !aux_req && !done, "R1", "quiet after reset", int'(busy), 0);
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule